// File: doc/BRIEF.md
# Auto-Reload Serial Bit-Rate Generator

This block makes the timing strobes for a serial port that has four framing modes. A free-running prescaler divides the oscillator clock by twelve into machine cycles. An 8-bit timer counts those machine cycles while a run bit is high. When the timer steps past 0xFF it loads a software-supplied reload byte and raises a sticky overflow flag. The flag stays set until software clears it.

Two outputs come from this chain. The first is a single-cycle shift strobe at one twelfth of the oscillator rate, used by the synchronous shift mode. The second is a single-cycle strobe at sixteen times the bit rate, used by the asynchronous modes. That strobe comes either from a short fixed divider on the oscillator or from timer overflows. A rate-double input halves the division in each case. Both outputs are pulses in the clock domain, not derived clocks.

The reload byte for a wanted bit rate is 256 − fosc/(384·baud) with rate-double clear, or 256 − fosc/(192·baud) with it set. For example, 0xFD gives 9600 baud from an 11.059 MHz oscillator with rate-double clear.

Top module: `bitrate_gen`

## Requirements
- R1: While reset is low, and in the cycle after it is released, `tmr_count` is 0x00, `ovf_flag` is 0, and neither strobe is high.
- R2: While `run` is 1, `tmr_count` rises by one every 12 clock cycles. While `run` is 0 it holds its value. The prescaler keeps running either way.
- R3: When `tmr_count` steps from 0xFF, `ovf_flag` becomes 1. It stays 1 until `ovf_clr` is high for a cycle. If a clear and an overflow fall in the same cycle, the flag stays set.
- R4: `reload` is sampled only when the timer overflows. Changing it mid-count does not change `tmr_count`. After the next overflow, `tmr_count` equals the new byte.
- R5: With `mode` = 2'b00, `shift_stb` pulses once every 12 clock cycles whatever `rate_dbl` and `run` are, and `os_stb` stays low.
- R6: With `mode` = 2'b10, `os_stb` pulses every 4 clock cycles when `rate_dbl` = 0 and every 2 cycles when `rate_dbl` = 1. This gives fosc/64 and fosc/32 bit rates. `shift_stb` stays low.
- R7: With `mode` = 2'b01 or 2'b11, `os_stb` pulses on every second timer overflow when `rate_dbl` = 0 and on every overflow when `rate_dbl` = 1. The period is 12·(256 − reload)·2 or 12·(256 − reload) clocks. With a reload of 0xFF the timer overflows every 12 cycles.
- R8: In modes 2'b01 and 2'b11 with `run` = 0, `os_stb` never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Timer run control |
| reload | input | 8 | Auto-reload byte |
| rate_dbl | input | 1 | Halves the final division when 1 |
| mode | input | 2 | Serial mode select, 0 to 3 |
| ovf_clr | input | 1 | Clears the overflow flag |
| tmr_count | output | 8 | Current timer value |
| ovf_flag | output | 1 | Sticky overflow flag |
| shift_stb | output | 1 | Shift-mode strobe, fosc/12 |
| os_stb | output | 1 | 16x oversampling strobe for asynchronous modes |

## Verification
The assertions check the following on every cycle:
- the timer holds while stopped;
- the timer steps only by one or through an overflow;
- any overflow leaves the flag set;
- each strobe stays low in the modes that do not use it.

Only the bench scenarios can show the actual periods of the strobes across modes, rate-double settings and reload values. The bench also shows that a reload written mid-count waits for the next overflow, and that a set collides with a clear in favour of the set.

// File: rtl/bitrate_gen.sv
module bitrate_gen #(
  parameter int PRE_DIV = 12,
  parameter int TW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] reload,
  input  logic          rate_dbl,
  input  logic [1:0]    mode,
  input  logic          ovf_clr,
  output logic [TW-1:0] tmr_count,
  output logic          ovf_flag,
  output logic          shift_stb,
  output logic          os_stb
);
  localparam int PW = $clog2(PRE_DIV);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);
  localparam logic [TW-1:0] TMAX = '1;

  logic [PW-1:0] pre_q;
  logic [1:0]    fdiv_q;
  logic          half_q;
  logic          mc_tick, ovf, os_next;

  assign mc_tick = (pre_q == PRE_LAST);
  assign ovf     = run & mc_tick & (tmr_count == TMAX);

  always_comb begin
    case (mode)
      2'b00:   os_next = 1'b0;
      2'b10:   os_next = rate_dbl ? fdiv_q[0] : (fdiv_q == 2'b11);
      default: os_next = ovf & (rate_dbl | half_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q     <= '0;
      fdiv_q    <= '0;
      half_q    <= 1'b0;
      tmr_count <= '0;
      ovf_flag  <= 1'b0;
      shift_stb <= 1'b0;
      os_stb    <= 1'b0;
    end else begin
      pre_q  <= mc_tick ? '0 : pre_q + 1'b1;
      fdiv_q <= fdiv_q + 2'd1;
      if (run && mc_tick)
        tmr_count <= (tmr_count == TMAX) ? reload : tmr_count + 1'b1;
      if (ovf) begin
        half_q   <= ~half_q;
        ovf_flag <= 1'b1;
      end else if (ovf_clr) begin
        ovf_flag <= 1'b0;
      end
      shift_stb <= (mode == 2'b00) & mc_tick;
      os_stb    <= os_next;
    end
  end
endmodule

// File: rtl/bitrate_gen_chk.sv
module bitrate_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic [1:0] mode,
  input logic [7:0] tmr_count,
  input logic       ovf_flag,
  input logic       shift_stb,
  input logic       os_stb
);
  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(tmr_count));

  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tmr_count) != tmr_count && $past(tmr_count) != 8'hFF) |-> tmr_count == $past(tmr_count) + 8'd1);

  a_r3_flag_on_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tmr_count) == 8'hFF && tmr_count != 8'hFF) |-> ovf_flag);

  a_r5_no_os_in_shift_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b00) |-> !os_stb);

  a_r6_no_shift_outside_mode0: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) != 2'b00) |-> !shift_stb);

  a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shift_stb, os_stb}));
endmodule

bind bitrate_gen bitrate_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .tmr_count(tmr_count),
  .ovf_flag(ovf_flag), .shift_stb(shift_stb), .os_stb(os_stb));

// File: tb/bitrate_gen_tb_top.sv
`timescale 1ns/1ps
module bitrate_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [7:0] reload = 8'h00;
  logic       rate_dbl = 1'b0;
  logic [1:0] mode = 2'b01;
  logic       ovf_clr = 1'b0;
  logic [7:0] tmr_count;
  logic       ovf_flag, shift_stb, os_stb;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bitrate_gen dut_i (.*);

  // {mode, rate_dbl, reload, expected period in clocks}
  localparam logic [26:0] VEC [11] = '{
    {2'b00, 1'b0, 8'h00, 16'd12},
    {2'b00, 1'b1, 8'h00, 16'd12},
    {2'b10, 1'b0, 8'h00, 16'd4},
    {2'b10, 1'b1, 8'h00, 16'd2},
    {2'b01, 1'b0, 8'hFD, 16'd72},
    {2'b01, 1'b1, 8'hFD, 16'd36},
    {2'b11, 1'b0, 8'hFA, 16'd144},
    {2'b11, 1'b1, 8'hFA, 16'd72},
    {2'b01, 1'b1, 8'hD0, 16'd576},
    {2'b11, 1'b0, 8'hA0, 16'd2304},
    {2'b11, 1'b1, 8'hFF, 16'd12}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic meas(input bit use_shift, input int exp_per, input string req);
    int seen = 0;
    int t0 = 0;
    int t1 = 0;
    int other = 0;
    while (seen < 4) begin
      @(negedge clk);
      if (use_shift ? shift_stb : os_stb) begin
        seen++;
        if (seen == 3) t0 = cyc;
        if (seen == 4) t1 = cyc;
      end
      if (seen >= 1 && (use_shift ? os_stb : shift_stb)) other++;
    end
    chk(t1 - t0 == exp_per, req, t1 - t0, exp_per);
    chk(other == 0, {req, " other strobe idle"}, other, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c0;
    repeat (4) @(negedge clk);
    // R1 state under reset
    chk(tmr_count == 8'h00, "R1 count in reset", tmr_count, 0);
    chk(!ovf_flag && !shift_stb && !os_stb, "R1 flag/strobes in reset",
        {ovf_flag, shift_stb, os_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tmr_count == 8'h00 && !ovf_flag, "R1 after release", tmr_count, 0);

    // R2 hold while stopped
    repeat (50) @(negedge clk);
    chk(tmr_count == 8'h00, "R2 hold while stopped", tmr_count, 0);

    // R2 counting every 12 cycles
    run = 1'b1;
    c0 = 0;
    while (tmr_count == 8'h00 && c0 < 40) begin @(negedge clk); c0++; end
    chk(tmr_count == 8'h01, "R2 first step", tmr_count, 1);
    repeat (12) @(negedge clk);
    chk(tmr_count == 8'h02, "R2 step after 12 clocks", tmr_count, 2);

    // R4 reload change mid-count has no immediate effect
    reload = 8'hF8;
    repeat (12) @(negedge clk);
    chk(tmr_count == 8'h03, "R4 mid-count reload ignored", tmr_count, 3);

    run = 1'b0;
    repeat (40) @(negedge clk);
    chk(tmr_count == 8'h03, "R2 hold after stop", tmr_count, 3);
    run = 1'b1;

    while (tmr_count != 8'hFF) @(negedge clk);
    chk(!ovf_flag, "R3 flag clear before overflow", ovf_flag, 0);
    repeat (11) @(negedge clk);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk(tmr_count == 8'hF8, "R4 reload applied at overflow", tmr_count, 8'hF8);
    chk(ovf_flag, "R3 set wins over clear", ovf_flag, 1);
    @(negedge clk);
    chk(ovf_flag, "R3 flag sticky", ovf_flag, 1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk(!ovf_flag, "R3 clear drops flag", ovf_flag, 0);
    repeat (100) @(negedge clk);
    chk(ovf_flag, "R3 flag set by next overflow", ovf_flag, 1);

    // R8 no oversampling strobe with timer stopped in timer-driven modes
    mode = 2'b01;
    rate_dbl = 1'b1;
    run = 1'b0;
    @(negedge clk);
    c0 = 0;
    repeat (800) begin @(negedge clk); if (os_stb) c0++; end
    chk(c0 == 0, "R8 no os strobe while stopped", c0, 0);

    // R5 R6 R7 period table
    run = 1'b1;
    for (int i = 0; i < 11; i++) begin
      mode     = VEC[i][26:25];
      rate_dbl = VEC[i][24];
      reload   = VEC[i][23:16];
      if (VEC[i][26:25] == 2'b00)
        meas(1'b1, int'(VEC[i][15:0]), "R5 shift period");
      else if (VEC[i][26:25] == 2'b10)
        meas(1'b0, int'(VEC[i][15:0]), "R6 fixed os period");
      else
        meas(1'b0, int'(VEC[i][15:0]), "R7 timer os period");
    end

    // R5 shift strobe independent of run
    mode = 2'b00;
    run = 1'b0;
    meas(1'b1, 12, "R5 shift period with run low");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule